// File: doc/BRIEF.md
# Text Line Glyph Streamer

This block turns a run of character codes into the byte stream that a page-organized monochrome graphic display controller accepts. A single start pulse carries a target page (one 8-pixel-high text row) and a starting column. The block then emits three command bytes that set the page and the column address. After those it emits eight column bytes for each character, read from an internal font ROM. Every byte on the output is tagged as either a command or display data.

Character codes come in over a valid/ready handshake. The block takes a new code only after all eight bytes of the previous glyph have been issued. A glyph byte counter decides when the next code is fetched, and the ROM address is the code with that 3-bit counter appended. The font ROM is computed inside the design, so no external content is needed. Pages are addressed in display RAM terms, not panel terms.

A line ends in one of two ways: after the character flagged as last, or when the next character would not fit in the row. A one-cycle done pulse marks the end once every byte has left the output register. A character that did not fit stays at the text source, so it can start the next line.

Top module: `txs_top`

## Requirements
- R1: While reset is applied and right after it, `out_valid`, `txt_ready` and `done` are all low.
- R2: After an accepted start, the first three output bytes have `out_cmd`=1. They are, in order: 0xB0 OR page; 0x10 OR column bits [7:4]; 0x00 OR column bits [3:0].
- R3: Each character produces eight bytes with `out_cmd`=0, for byte index i=0..7 at ROM address a = code*8+i. The byte value is 0 when i=7; otherwise it is (a*29+7) mod 256.
- R4: A code is taken on a cycle where `txt_valid` and `txt_ready` are both high. After a code is taken, `txt_ready` is low on the next cycle, and no further code is taken until that character's eight bytes have been issued.
- R5: The column advances by 8 per character. When the next character would start beyond column COLS-8 (124 by default), it is neither taken nor emitted, and the line ends.
- R6: `done` pulses high for exactly one cycle per line, only when `out_valid` is low. This happens after the last-flagged character's bytes, or after an overflow stop.
- R7: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_cmd` hold steady. Every byte is transferred exactly once, in order, whatever the pattern of stalls.
- R8: A start pulse that arrives while a line is in progress is ignored. No extra command bytes are produced and the current line is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a line (taken only when idle) |
| start_page | input | PAGE_W (3) | Target display RAM page |
| start_col | input | COL_W (8) | Starting column |
| txt_valid | input | 1 | Character code available |
| txt_code | input | CODE_W (7) | Character code |
| txt_last | input | 1 | This code is the final one of the line |
| txt_ready | output | 1 | Streamer takes the code this cycle |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Command or column byte |
| out_cmd | output | 1 | 1 = command byte, 0 = display data |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The properties check the per-cycle handshake rules on every clock. These are: the output holds during stalls, the text port shows its one-cycle gap after each taken code, and done is a single pulse that only occurs with an empty output stage. Byte values, ordering, the header contents, and where the overflow stop falls for a given start column can only be shown by the bench. It compares the whole transferred stream and the number of consumed codes against a model. The stimulus covers random stalls, column boundaries at 124 and 125, and a start pulse issued mid-line.

// File: rtl/txs_pkg.sv
package txs_pkg;

  localparam int IDX_W       = 3;
  localparam int GLYPH_BYTES = 1 << IDX_W;

  localparam logic [7:0] CMD_PAGE  = 8'hB0;
  localparam logic [7:0] CMD_COLHI = 8'h10;
  localparam logic [7:0] CMD_COLLO = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE, S_PAGE, S_CHI, S_CLO, S_FETCH, S_GLYPH, S_DRAIN
  } txs_state_e;

  // Computed font content: last column of every glyph is blank spacing.
  function automatic logic [7:0] glyph_byte(input logic [15:0] addr);
    logic [15:0] mix;
    mix = addr * 16'd29 + 16'd7;
    if (addr[IDX_W-1:0] == {IDX_W{1'b1}}) return 8'h00;
    return mix[7:0];
  endfunction

endpackage

// File: rtl/txs_rst_sync.sv
module txs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/txs_seq.sv
module txs_seq
  import txs_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int COLS   = 132,
  parameter int PAGES  = 8,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int COL_W  = $clog2(COLS + 1),
  localparam int ADDR_W = CODE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [COL_W-1:0]  start_col,
  input  logic              txt_valid,
  input  logic [CODE_W-1:0] txt_code,
  input  logic              txt_last,
  output logic              txt_ready,
  input  logic              out_valid,
  input  logic              out_ready,
  output logic              ld,
  output logic              ld_cmd,
  output logic [7:0]        ld_cmd_byte,
  output logic [ADDR_W-1:0] ld_addr,
  output logic              done
);
  localparam logic [COL_W-1:0] LAST_START = COL_W'(COLS - GLYPH_BYTES);

  txs_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              last_q, last_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              room, ovf;
  logic [7:0]        col8;

  assign room    = !out_valid || out_ready;
  assign ovf     = col_q > LAST_START;
  assign col8    = 8'(col_q);
  assign ld_addr = {code_q, idx_q};

  always_comb begin
    state_d     = state_q;
    page_d      = page_q;
    col_d       = col_q;
    code_d      = code_q;
    last_d      = last_q;
    idx_d       = idx_q;
    ld          = 1'b0;
    ld_cmd      = 1'b0;
    ld_cmd_byte = 8'h00;
    txt_ready   = 1'b0;
    done        = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        state_d = S_PAGE;
        page_d  = start_page;
        col_d   = start_col;
      end
      S_PAGE: begin
        ld_cmd      = 1'b1;
        ld_cmd_byte = CMD_PAGE | 8'(page_q);
        if (room) begin ld = 1'b1; state_d = S_CHI; end
      end
      S_CHI: begin
        ld_cmd      = 1'b1;
        ld_cmd_byte = CMD_COLHI | {4'h0, col8[7:4]};
        if (room) begin ld = 1'b1; state_d = S_CLO; end
      end
      S_CLO: begin
        ld_cmd      = 1'b1;
        ld_cmd_byte = CMD_COLLO | {4'h0, col8[3:0]};
        if (room) begin ld = 1'b1; state_d = S_FETCH; end
      end
      S_FETCH: begin
        txt_ready = !ovf;
        if (ovf) begin
          state_d = S_DRAIN;
        end else if (txt_valid) begin
          code_d  = txt_code;
          last_d  = txt_last;
          idx_d   = '0;
          state_d = S_GLYPH;
        end
      end
      S_GLYPH: if (room) begin
        ld    = 1'b1;
        idx_d = idx_q + 1'b1;
        col_d = col_q + 1'b1;
        if (idx_q == {IDX_W{1'b1}}) state_d = last_q ? S_DRAIN : S_FETCH;
      end
      S_DRAIN: if (!out_valid) begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      page_q  <= '0;
      col_q   <= '0;
      code_q  <= '0;
      last_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      col_q   <= col_d;
      code_q  <= code_d;
      last_q  <= last_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/txs_out_reg.sv
module txs_out_reg
  import txs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              ld_cmd,
  input  logic [7:0]        ld_cmd_byte,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              out_cmd
);
  logic       valid_d;
  logic [7:0] byte_d;

  always_comb begin
    valid_d = out_valid;
    if (ld)             valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    byte_d = ld_cmd ? ld_cmd_byte : glyph_byte(16'(ld_addr));
  end

  // The ROM read register doubles as the output stage; enable = ld.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
      out_cmd   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (ld) begin
        out_byte <= byte_d;
        out_cmd  <= ld_cmd;
      end
    end
  end
endmodule

// File: rtl/txs_top.sv
module txs_top
  import txs_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int COLS   = 132,
  parameter int PAGES  = 8,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int COL_W  = $clog2(COLS + 1),
  localparam int ADDR_W = CODE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [COL_W-1:0]  start_col,
  input  logic              txt_valid,
  input  logic [CODE_W-1:0] txt_code,
  input  logic              txt_last,
  output logic              txt_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_cmd,
  output logic              done
);
  logic              rst_sn;
  logic              ld, ld_cmd;
  logic [7:0]        ld_cmd_byte;
  logic [ADDR_W-1:0] ld_addr;

  txs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  txs_seq #(.CODE_W(CODE_W), .COLS(COLS), .PAGES(PAGES)) u_seq (
    .clk(clk), .rst_n(rst_sn), .start(start), .start_page(start_page),
    .start_col(start_col), .txt_valid(txt_valid), .txt_code(txt_code),
    .txt_last(txt_last), .txt_ready(txt_ready), .out_valid(out_valid),
    .out_ready(out_ready), .ld(ld), .ld_cmd(ld_cmd),
    .ld_cmd_byte(ld_cmd_byte), .ld_addr(ld_addr), .done(done)
  );

  txs_out_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_sn), .ld(ld), .ld_cmd(ld_cmd),
    .ld_cmd_byte(ld_cmd_byte), .ld_addr(ld_addr), .out_ready(out_ready),
    .out_valid(out_valid), .out_byte(out_byte), .out_cmd(out_cmd)
  );
endmodule

// File: rtl/txs_chk.sv
module txs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txt_valid,
  input logic       txt_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_cmd,
  input logic       done
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_cmd));

  assert_done_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_txt_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txt_valid && txt_ready |=> !txt_ready);

  assert_cmd_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cmd |-> out_byte[7:4] inside {4'hB, 4'h1, 4'h0});

  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !done);
endmodule

bind txs_top txs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txt_valid(txt_valid), .txt_ready(txt_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .out_cmd(out_cmd), .done(done)
);

// File: tb/tb_txs_top.sv
module tb_txs_top;
  logic       clk = 1'b0;
  logic       rst_n, start, txt_valid, txt_last, out_ready;
  logic [2:0] start_page;
  logic [7:0] start_col;
  logic [6:0] txt_code;
  logic       txt_ready, out_valid, out_cmd, done;
  logic [7:0] out_byte;

  int errors = 0, checks = 0;
  int txt[64];
  int exp_b[256], got_b[256];
  bit exp_c[256], got_c[256];

  always #10 clk = ~clk;

  txs_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .start_col(start_col), .txt_valid(txt_valid), .txt_code(txt_code),
    .txt_last(txt_last), .txt_ready(txt_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_cmd(out_cmd), .done(done)
  );

  function automatic int glyph(int code, int i);
    int a;
    a = code * 8 + i;
    if (i == 7) return 0;
    return (a * 29 + 7) % 256;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_line(int page, int col, int n, bit stall, bit spur);
    int ne, nchar, ng, src, cyc, dones, after, gap_err, ncmd, bad_hdr, bad_dat, bad_at;
    bit acc_prev;
    nchar = 0;
    exp_b[0] = 8'hB0 | page; exp_b[1] = 8'h10 | (col >> 4); exp_b[2] = col & 15;
    for (int k = 0; k < 3; k++) exp_c[k] = 1'b1;
    ne = 3;
    for (int k = 0; k < n; k++) begin
      if (col + 8 * k > 124) break;
      for (int i = 0; i < 8; i++) begin
        exp_b[ne] = glyph(txt[k], i); exp_c[ne] = 1'b0; ne++;
      end
      nchar++;
    end
    @(negedge clk);
    start = 1'b1; start_page = 3'(page); start_col = 8'(col);
    ng = 0; src = 0; cyc = 0; dones = 0; after = 0; gap_err = 0; acc_prev = 0;
    while (after < 6) begin
      @(negedge clk);
      cyc++;
      start = spur && (cyc == 4);
      if (spur) begin start_page = 3'(~page); start_col = 8'd3; end
      out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      txt_valid = src < n;
      txt_code  = 7'(txt[src < n ? src : 0]);
      txt_last  = (src == n - 1);
      #1;
      if (acc_prev && txt_ready) gap_err++;
      acc_prev = txt_valid && txt_ready;
      if (acc_prev) src++;
      if (out_valid && out_ready && ng < 256) begin
        got_b[ng] = out_byte; got_c[ng] = out_cmd; ng++;
      end
      if (done) dones++;
      if (dones > 0) after++;
      if (cyc > 3000) begin
        chk(0, "R6", "watchdog line stuck", cyc, 3000);
        break;
      end
    end
    txt_valid = 1'b0; start = 1'b0;
    chk(ng == ne, "R7", "byte count", ng, ne);
    bad_hdr = 0; bad_dat = 0; bad_at = 0; ncmd = 0;
    for (int k = 0; k < ng && k < ne; k++) begin
      if (got_c[k]) ncmd++;
      if (got_b[k] != exp_b[k] || got_c[k] != exp_c[k]) begin
        if (k < 3) bad_hdr++; else begin if (bad_dat == 0) bad_at = k; bad_dat++; end
      end
    end
    chk(bad_hdr == 0, "R2", "header bytes wrong", bad_hdr, 0);
    chk(bad_dat == 0, "R3", "glyph byte mismatch",
        bad_dat == 0 ? 0 : got_b[bad_at], bad_dat == 0 ? 0 : exp_b[bad_at]);
    chk(src == nchar, "R5", "codes consumed", src, nchar);
    chk(dones == 1, "R6", "done pulses", dones, 1);
    chk(gap_err == 0, "R4", "ready not low after take", gap_err, 0);
    if (spur) chk(ncmd == 3, "R8", "command bytes with mid-line start", ncmd, 3);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; start_page = '0; start_col = '0;
    txt_valid = 1'b0; txt_code = '0; txt_last = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !txt_ready && !done, "R1", "outputs during reset",
        {out_valid, txt_ready, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid && !txt_ready && !done, "R1", "outputs after reset",
        {out_valid, txt_ready, done}, 0);

    for (int k = 0; k < 20; k++) txt[k] = (k * 13) % 128;
    txt[0] = 0; txt[1] = 127;
    run_line(0, 0, 20, 0, 0);      // 16 chars fit, overflow stop (R5)
    run_line(7, 124, 1, 1, 0);     // exactly reaches column 132
    run_line(3, 125, 2, 1, 0);     // nothing fits (R5)
    run_line(1, 117, 3, 1, 0);     // one fits
    run_line(5, 10, 6, 1, 1);      // start while busy ignored (R8)
    for (int t = 0; t < 10; t++) begin
      int n, c;
      n = 1 + ($urandom % 12);
      c = $urandom % 140;
      for (int k = 0; k < n; k++) txt[k] = $urandom % 128;
      run_line($urandom % 8, c, n, 1, (c <= 100 && n >= 4));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule